// File: doc/BRIEF.md
# Compressed Instruction Field Extractor

This block unpacks one bank of fine-grain compressed configuration words. Such a bank holds a single kind of instruction field, for example opcodes or constants, and every field in it has the same width. An instruction keeps only the fields it actually uses, placed back to back with no gaps. No format word is stored. In each cycle the surrounding control logic says which units need a field by raising one read strobe per requester. The block then hands out the next unread fields of the bank, in order, to exactly those requesters.

Inside, a configuration memory with a write port feeds an input register two word lines deep. The register keeps the next unread bit at its top, which is where the align stage takes it from. A field reader then carves out a small number of field slots and routes them to the strobing requesters. The pool of slots can be smaller than the number of requesters. After each cycle the bit pointer advances by the number of fields consumed. A fresh word line is appended whenever the unread bits could no longer cover one cycle of worst-case demand. A restart pulse, given at the start of each kernel loop, rewinds the stream to the first word line and preloads both buffer lines. Outputs are registered, so they appear one cycle after the strobes. This matches data that arrives one cycle after the requests.

Top module: `ccx_field_extract`

## Requirements
- R1: While rst_n is low and after it, until the first strobe, every bit of fld_vld and the ovf flag read 0.
- R2: The fields form one continuous stream. Field n occupies bits n*FIELD_W to n*FIELD_W+FIELD_W-1 of the bank, counted from bit LINE_W-1 of word line 0 downward, each field MSB first. The k-th field handed out after a restart is field k.
- R3: Within one cycle, fields go to the strobing requesters in ascending requester index. The lowest-index strober gets the oldest unread field.
- R4: When more than N_SLOT strobes are high, only the N_SLOT lowest-index strobers are served. In the following cycle ovf is 1, and the pointer advances by exactly N_SLOT fields. Otherwise ovf is 0.
- R5: fld_vld[i] and fld_data for requester i change one clock after the strobe. fld_vld[i] is 1 only if rd_stb[i] was 1 in the cycle before.
- R6: A field whose bits straddle two consecutive word lines is delivered whole and correct.
- R7: A restart pulse rewinds the stream so that the next field served is field 0. Strobes in the restart cycle are ignored: the following cycle shows fld_vld all 0 and ovf 0, and nothing is consumed.
- R8: A cycle with no strobe consumes no field, and all fld_vld bits are 0 in the next cycle.
- R9: N_SLOT fields can be drawn every cycle, without stalls, for any number of consecutive cycles.
- R10: A word line written through the write port is the content used by the next restart and by later refills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Kernel-loop restart: rewind to word line 0 |
| wr_en | input | 1 | Configuration memory write enable |
| wr_addr | input | ADDR_W | Configuration memory write line address |
| wr_data | input | LINE_W | Configuration memory write line |
| rd_stb | input | N_REQ | Per-requester field read strobes |
| fld_data | output | N_REQ*FIELD_W | Delivered fields, requester i at bits i*FIELD_W upward |
| fld_vld | output | N_REQ | Per-requester field valid, one cycle after the strobe |
| ovf | output | 1 | Strobe count exceeded the slot pool in the previous cycle |

## Verification
The bench builds the block with 10-bit fields in 64-bit lines, 6 slots, 9 requesters and a 32-line memory. Because 10 does not divide 64, fields straddle line boundaries at shifting offsets, so R6 comes up often. With more requesters than slots, the overflow path of R4 is reachable with ordinary strobe vectors. The memory is deep enough that long stretches at full six-field demand run through many refills before the bench forces a restart to stay inside the written stream.

// File: rtl/ccx_pkg.sv
// Shared helpers for the compressed field extractor.
// Assumes nothing beyond integer arithmetic at elaboration and run time.
package ccx_pkg;

    // Smaller of two counts; used to cap the consumed field count at the slot pool.
    function automatic int unsigned cap_count(input int unsigned value, input int unsigned limit);
        return (value > limit) ? limit : value;
    endfunction

endpackage

// File: rtl/ccx_cfg_mem.sv
// Configuration memory model: one write port and two read ports.
// Reads are combinational here. The only consumer captures them into its
// line register at the clock edge, so the pair behaves as a synchronous memory.
// Assumes DEPTH is a power of two.
module ccx_cfg_mem #(
    parameter int LINE_W = 64,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ra0,
    input  logic [ADDR_W-1:0] ra1,
    output logic [LINE_W-1:0] rd0,
    output logic [LINE_W-1:0] rd1
);
    logic [LINE_W-1:0] mem_q [DEPTH];

    // Write one word line per enabled cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Present both addressed lines to the capturing register.
    always_comb begin
        rd0 = mem_q[ra0];
        rd1 = mem_q[ra1];
    end
endmodule

// File: rtl/ccx_slot_alloc.sv
// Slot allocator: counts the strobes and ranks each requester among the
// strobers below it. It marks which strobers fit in the slot pool and flags an
// over-subscribed cycle. Purely combinational.
module ccx_slot_alloc
    import ccx_pkg::*;
#(
    parameter int N_REQ  = 12,
    parameter int N_SLOT = 8,
    parameter int RANK_W = $clog2(N_REQ + 1)
) (
    input  logic [N_REQ-1:0]             stb,
    output logic [N_REQ-1:0][RANK_W-1:0] rank,
    output logic [N_REQ-1:0]             served,
    output logic [RANK_W-1:0]            n_take,
    output logic                         over
);
    // Running prefix count gives ascending-index slot ranks.
    always_comb begin
        int unsigned run;
        run = 0;
        for (int i = 0; i < N_REQ; i++) begin
            rank[i]   = RANK_W'(run);
            served[i] = stb[i] && (run < N_SLOT);
            run       = run + int'(stb[i]);
        end
        n_take = RANK_W'(cap_count(run, N_SLOT));
        over   = (run > N_SLOT);
    end
endmodule

// File: rtl/ccx_line_buffer.sv
// Input register and align stage. It holds two word lines with the next unread
// bit kept at the top, so the top N_SLOT*FIELD_W bits are the next fields in
// order. Each cycle it drops the consumed bits. It appends one line when the
// remaining bits fall below one cycle of worst-case demand. Restart preloads
// lines 0 and 1. Assumes N_SLOT*FIELD_W <= LINE_W.
module ccx_line_buffer #(
    parameter int FIELD_W = 8,
    parameter int LINE_W  = 64,
    parameter int N_SLOT  = 8,
    parameter int DEPTH   = 16,
    parameter int ADDR_W  = $clog2(DEPTH),
    parameter int RANK_W  = 4,
    localparam int BUF_W  = 2 * LINE_W,
    localparam int WIN_W  = N_SLOT * FIELD_W,
    localparam int CNT_W  = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RANK_W-1:0] n_take,
    output logic [ADDR_W-1:0] ra0,
    output logic [ADDR_W-1:0] ra1,
    input  logic [LINE_W-1:0] rd0,
    input  logic [LINE_W-1:0] rd1,
    output logic [WIN_W-1:0]  window
);
    localparam int DEMAND = WIN_W;

    logic [BUF_W-1:0]  buf_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  used_bits;
    logic [CNT_W-1:0]  cnt_rem;
    logic              do_fetch;
    logic [BUF_W-1:0]  shifted;
    logic [BUF_W-1:0]  appended;

    // Bits consumed this cycle, bits left afterwards, and the refill decision.
    always_comb begin
        used_bits = CNT_W'(n_take) * CNT_W'(FIELD_W);
        cnt_rem   = (cnt_q > used_bits) ? (cnt_q - used_bits) : '0;
        do_fetch  = (cnt_rem < CNT_W'(DEMAND));
        shifted   = buf_q << used_bits;
        appended  = shifted | ({rd0, {LINE_W{1'b0}}} >> cnt_rem);
    end

    // Read addresses: restart reads lines 0 and 1, otherwise the next line.
    always_comb begin
        ra0 = restart ? '0 : addr_q;
        ra1 = ADDR_W'(1);
    end

    // Buffer, fill count and fetch address update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (restart) begin
            buf_q  <= {rd0, rd1};
            cnt_q  <= CNT_W'(BUF_W);
            addr_q <= ADDR_W'(2);
        end else if (do_fetch) begin
            buf_q  <= appended;
            cnt_q  <= cnt_rem + CNT_W'(LINE_W);
            addr_q <= addr_q + 1'b1;
        end else begin
            buf_q  <= shifted;
            cnt_q  <= cnt_rem;
        end
    end

    // Aligned window of the next unread fields.
    always_comb begin
        window = buf_q[BUF_W-1 -: WIN_W];
    end
endmodule

// File: rtl/ccx_field_reader.sv
// Field reader: steers slot[rank] of the aligned window to each served
// requester and registers data, valid and the over-subscription flag.
// A restart cycle clears all valids and the flag.
module ccx_field_reader #(
    parameter int FIELD_W = 8,
    parameter int N_REQ   = 12,
    parameter int N_SLOT  = 8,
    parameter int RANK_W  = 4,
    localparam int WIN_W  = N_SLOT * FIELD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         restart,
    input  logic [WIN_W-1:0]             window,
    input  logic [N_REQ-1:0][RANK_W-1:0] rank,
    input  logic [N_REQ-1:0]             served,
    input  logic                         over,
    output logic [N_REQ*FIELD_W-1:0]     fld_data,
    output logic [N_REQ-1:0]             fld_vld,
    output logic                         ovf
);
    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        logic [FIELD_W-1:0] pick;

        // Select the slot this requester ranks into (slot 0 when not served).
        always_comb begin
            int base;
            base = WIN_W - 1 - (served[g] ? int'(rank[g]) : 0) * FIELD_W;
            pick = window[base -: FIELD_W];
        end

        // Register the field and its valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld_data[g*FIELD_W +: FIELD_W] <= '0;
                fld_vld[g]                     <= 1'b0;
            end else begin
                fld_vld[g] <= served[g] && !restart;
                if (served[g] && !restart) begin
                    fld_data[g*FIELD_W +: FIELD_W] <= pick;
                end
            end
        end
    end

    // Register the over-subscription flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else begin
            ovf <= over && !restart;
        end
    end
endmodule

// File: rtl/ccx_field_extract.sv
// Top of the compressed instruction field extractor for one same-type bank.
// Strobes in cycle t select fields, which appear registered in cycle t+1.
// A restart pulse must precede the first strobe after reset.
// Assumes N_SLOT*FIELD_W <= LINE_W and DEPTH a power of two.
module ccx_field_extract #(
    parameter int FIELD_W = 8,
    parameter int LINE_W  = 64,
    parameter int N_SLOT  = 8,
    parameter int N_REQ   = 12,
    parameter int DEPTH   = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int RANK_W = $clog2(N_REQ + 1),
    localparam int WIN_W  = N_SLOT * FIELD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LINE_W-1:0]        wr_data,
    input  logic [N_REQ-1:0]         rd_stb,
    output logic [N_REQ*FIELD_W-1:0] fld_data,
    output logic [N_REQ-1:0]         fld_vld,
    output logic                     ovf
);
    logic [ADDR_W-1:0]            ra0;
    logic [ADDR_W-1:0]            ra1;
    logic [LINE_W-1:0]            rd0;
    logic [LINE_W-1:0]            rd1;
    logic [N_REQ-1:0][RANK_W-1:0] rank;
    logic [N_REQ-1:0]             served;
    logic [RANK_W-1:0]            n_take;
    logic                         over;
    logic [RANK_W-1:0]            n_take_eff;
    logic [WIN_W-1:0]             window;

    // Nothing is consumed in a restart cycle.
    always_comb begin
        n_take_eff = restart ? '0 : n_take;
    end

    ccx_cfg_mem #(.LINE_W(LINE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ra0(ra0), .ra1(ra1), .rd0(rd0), .rd1(rd1)
    );

    ccx_slot_alloc #(.N_REQ(N_REQ), .N_SLOT(N_SLOT), .RANK_W(RANK_W)) u_alloc (
        .stb(rd_stb), .rank(rank), .served(served), .n_take(n_take), .over(over)
    );

    ccx_line_buffer #(
        .FIELD_W(FIELD_W), .LINE_W(LINE_W), .N_SLOT(N_SLOT),
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .RANK_W(RANK_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .restart(restart), .n_take(n_take_eff),
        .ra0(ra0), .ra1(ra1), .rd0(rd0), .rd1(rd1), .window(window)
    );

    ccx_field_reader #(
        .FIELD_W(FIELD_W), .N_REQ(N_REQ), .N_SLOT(N_SLOT), .RANK_W(RANK_W)
    ) u_rdr (
        .clk(clk), .rst_n(rst_n), .restart(restart), .window(window),
        .rank(rank), .served(served), .over(over),
        .fld_data(fld_data), .fld_vld(fld_vld), .ovf(ovf)
    );
endmodule

// File: rtl/ccx_field_extract_chk.sv
// Port-level checker for the field extractor, attached by bind.
module ccx_field_extract_chk #(
    parameter int N_REQ  = 12,
    parameter int N_SLOT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic [N_REQ-1:0] rd_stb,
    input logic [N_REQ-1:0] fld_vld,
    input logic             ovf
);
    assert_vld_follows_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_vld & ~$past(rd_stb)) == '0);

    assert_restart_blanks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (fld_vld == '0 && !ovf));

    assert_ovf_serves_pool_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ($countones(fld_vld) == N_SLOT));

    assert_ovf_raised_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && $countones(rd_stb) > N_SLOT) |=> ovf);

    assert_all_served_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && $countones(rd_stb) <= N_SLOT) |=> (fld_vld == $past(rd_stb) && !ovf));

    assert_idle_no_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb == '0) |=> (fld_vld == '0));
endmodule

bind ccx_field_extract ccx_field_extract_chk #(.N_REQ(N_REQ), .N_SLOT(N_SLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .rd_stb(rd_stb),
    .fld_vld(fld_vld), .ovf(ovf)
);

// File: tb/ccx_field_extract_tb.sv
module ccx_field_extract_tb;
    localparam int FW = 10;
    localparam int LW = 64;
    localparam int NS = 6;
    localparam int NR = 9;
    localparam int DP = 32;
    localparam int AW = 5;
    localparam int NF = (DP * LW) / FW;

    logic            clk;
    logic            rst_n;
    logic            restart;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [LW-1:0]   wr_data;
    logic [NR-1:0]   rd_stb;
    logic [NR*FW-1:0] fld_data;
    logic [NR-1:0]   fld_vld;
    logic            ovf;

    ccx_field_extract #(
        .FIELD_W(FW), .LINE_W(LW), .N_SLOT(NS), .N_REQ(NR), .DEPTH(DP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_stb(rd_stb),
        .fld_data(fld_data), .fld_vld(fld_vld), .ovf(ovf)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [FW-1:0] fv [NF];
    logic [LW-1:0] img [DP];
    logic [NR-1:0] e_vld;
    logic [FW-1:0] e_dat [NR];
    string         e_ftag [NR];
    logic          e_ovf;
    string         e_tag;
    int            p;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Compare outputs to the expectation computed one cycle earlier.
    task automatic compare();
        chk(e_tag, 32'(fld_vld), 32'(e_vld));
        chk("R4", 32'(ovf), 32'(e_ovf));
        for (int i = 0; i < NR; i++) begin
            if (e_vld[i]) chk(e_ftag[i], 32'(fld_data[i*FW +: FW]), 32'(e_dat[i]));
        end
    endtask

    // Drive one cycle of stimulus and compute what it must produce.
    task automatic step(input logic rs, input logic [NR-1:0] s, input string tag);
        int k;
        @(negedge clk);
        compare();
        if (!rs && p > NF - NS) begin
            rs = 1'b1;
            tag = "R7";
        end
        restart = rs;
        rd_stb = s;
        e_vld = '0;
        e_ovf = 1'b0;
        if (rs) begin
            p = 0;
            e_tag = "R7";
        end else begin
            k = 0;
            for (int i = 0; i < NR; i++) begin
                if (s[i] && k < NS) begin
                    e_vld[i] = 1'b1;
                    e_dat[i] = fv[p + k];
                    if (((p + k) * FW) % LW > LW - FW) e_ftag[i] = "R6";
                    else if (tag == "R9") e_ftag[i] = "R9";
                    else if ($countones(s) > 1) e_ftag[i] = "R3";
                    else e_ftag[i] = "R2";
                    k++;
                end
            end
            e_ovf = ($countones(s) > NS);
            p = p + k;
            e_tag = tag;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; restart = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_stb = '0;
        e_vld = '0; e_ovf = 1'b0; e_tag = "R1"; p = 0;
        for (int n = 0; n < NF; n++) fv[n] = FW'($urandom);
        for (int a = 0; a < DP; a++) img[a] = '0;
        for (int n = 0; n < NF; n++) begin
            for (int j = 0; j < FW; j++) begin
                int b;
                b = n * FW + j;
                img[b / LW][LW - 1 - (b % LW)] = fv[n][FW - 1 - j];
            end
        end
        repeat (3) @(negedge clk);
        chk("R1", 32'(fld_vld), 32'h0);
        chk("R1", 32'(ovf), 32'h0);
        rst_n = 1'b1;
        // R10: load the bank through the write port.
        for (int a = 0; a < DP; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = img[a];
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk("R1", 32'(fld_vld), 32'h0);
        step(1'b1, '0, "R7");
        step(1'b0, 9'b000000001, "R5");
        step(1'b0, 9'b000000000, "R8");
        step(1'b0, 9'b100000101, "R3");
        step(1'b0, 9'b111111111, "R4");
        step(1'b1, 9'b111111111, "R7");
        step(1'b0, 9'b000000010, "R7");
        repeat (30) step(1'b0, 9'b111111000, "R9");
        step(1'b1, '0, "R7");
        repeat (3000) begin
            logic [NR-1:0] s;
            int mode;
            mode = int'($urandom % 5);
            case (mode)
                0: s = NR'($urandom);
                1: s = NR'(1) << ($urandom % NR);
                2: s = '0;
                default: s = NR'($urandom) & NR'($urandom);
            endcase
            if ($urandom % 40 == 0) step(1'b1, s, "R7");
            else if (s == '0) step(1'b0, s, "R8");
            else if ($countones(s) > NS) step(1'b0, s, "R4");
            else step(1'b0, s, "R5");
        end
        step(1'b0, '0, "R8");
        @(negedge clk);
        compare();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule